// File: doc/BRIEF.md
# Dual-Port Byte-Lane Word Memory

This block is a synchronous, true dual-ported memory of 16-bit words. It has a left port and a right port, and each port has its own controls. Every control is active low: a chip select, a write strobe (low means write, high means read), an output enable, and two lane selects. The upper lane select covers bits 15:8 (lane 1). The lower lane select covers bits 7:0 (lane 0). Each port also has its own address, a write-data bus and a read-data bus.

Each port flags, one bit per lane, whether that lane of its read bus is actively driven. A lane that is not driven stands for a high-impedance pin. Each port also reports when it is in deselected standby.

Each port decodes its controls into one of five modes: standby, no lane selected, lane-masked write, lane-masked read, or outputs muted. The result is registered, so the read data, the lane-drive flags and the standby flag all appear one clock after the request. Both ports may read, and either may write, in the same cycle. Two rules settle collisions between the ports:
- When both ports write the same lane of the same word, the left port's data is stored.
- A read of a word that the other port writes in the same cycle returns the contents from before that write.

The address width defaults to 12 bits (4K words) and may be set to 13 or 14 bits.

Top module: `dp_byte_ram`

## Requirements
- R1: With chip select high, a port performs no access. One clock later it shows both lane-drive flags at 0, its read bus at zero, and its standby flag at 1.
- R2: With chip select low and both lane selects high, the port neither reads nor writes, whatever the other controls are. One clock later both lane-drive flags are 0 and the standby flag is 0.
- R3: With chip select low, write strobe low and at least one lane select low, only the lanes whose select is low are written at the addressed word. One clock later both lane-drive flags are 0.
- R4: With chip select low, write strobe high and output enable low, a port reads the addressed word. One clock later, drive flag 1 (upper) and flag 0 (lower) are 1 exactly for the lanes whose select is low. Those lanes carry the stored bytes, and every undriven lane of the read bus is zero.
- R5: With chip select low, write strobe high and output enable high, both lane-drive flags are 0 one clock later, whatever the lane selects are.
- R6: Both ports may read the same word in the same cycle, and each receives the stored contents.
- R7: When both ports write the same word in the same cycle, a lane written by both takes the left port's data. A lane written by only one port takes that port's data.
- R8: A read of a word that the other port writes in the same cycle returns the old contents. The new contents are returned by a later read.
- R9: During reset, both ports show both lane-drive flags at 0, the read bus at zero and the standby flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the port output registers |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_hi_n | input | 1 | Left upper-lane select (bits 15:8), active low |
| l_lo_n | input | 1 | Left lower-lane select (bits 7:0), active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, zero on undriven lanes |
| l_drive | output | 2 | Left lane-drive flags, bit 1 upper, bit 0 lower |
| l_sleep | output | 1 | Left deselected standby flag |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write strobe, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_hi_n | input | 1 | Right upper-lane select, active low |
| r_lo_n | input | 1 | Right lower-lane select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, zero on undriven lanes |
| r_drive | output | 2 | Right lane-drive flags, bit 1 upper, bit 0 lower |
| r_sleep | output | 1 | Right deselected standby flag |

## Verification
A write from one port can land in the same cycle as a write or a read from the other port at the same word. The bench provokes the write-write case by sweeping every pairing of nonempty lane masks on one address. Each pairing is read back through both ports at once, and the result is judged lane by lane against a reference word in which the right port's bytes are applied before the left port's. The write-read case is judged twice: the read in the colliding cycle must return the reference value from before the write, and a following read must return the updated value.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int NPORTS = 2;

    typedef enum logic [2:0] {
        M_SLEEP,
        M_NOLANE,
        M_WRITE,
        M_READ,
        M_MUTE
    } port_mode_e;

    typedef struct packed {
        logic [LANES-1:0]  drive;
        logic              sleep;
        logic [WORD_W-1:0] rdata;
    } port_out_t;
endpackage

// File: rtl/dp_word_store.sv
module dp_word_store
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NPORTS-1:0][LANES-1:0]        wr_lanes,
    input  logic [NPORTS-1:0][ADDR_W-1:0]       addr,
    input  logic [NPORTS-1:0][WORD_W-1:0]       wdata,
    output logic [NPORTS-1:0][WORD_W-1:0]       rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Lowest port index is applied last, so port 0 (left) wins a shared lane.
    always_ff @(posedge clk) begin
        for (int p = NPORTS - 1; p >= 0; p--) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lanes[p][l]) begin
                    mem_q[addr[p]][l*LANE_W +: LANE_W] <= wdata[p][l*LANE_W +: LANE_W];
                end
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        assign rd_word[p] = mem_q[addr[p]];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        p_left_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_lanes[0][l] && wr_lanes[1][l] && addr[0] == addr[1])
            |=> mem_q[$past(addr[0])][l*LANE_W +: LANE_W] == $past(wdata[0][l*LANE_W +: LANE_W]));
        p_right_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_lanes[1][l] && !(wr_lanes[0][l] && addr[0] == addr[1]))
            |=> mem_q[$past(addr[1])][l*LANE_W +: LANE_W] == $past(wdata[1][l*LANE_W +: LANE_W]));
    end
endmodule

// File: rtl/dp_port_unit.sv
module dp_port_unit
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  sel_n,
    input  logic [WORD_W-1:0] mem_word,
    output logic [LANES-1:0]  wr_lanes,
    output logic [LANES-1:0]  drive,
    output logic              sleep,
    output logic [WORD_W-1:0] rdata
);
    port_mode_e mode;
    port_out_t  out_d, out_q;

    always_comb begin
        if (cs_n)             mode = M_SLEEP;
        else if (&sel_n)      mode = M_NOLANE;
        else if (!we_n)       mode = M_WRITE;
        else if (!oe_n)       mode = M_READ;
        else                  mode = M_MUTE;

        wr_lanes    = (mode == M_WRITE) ? ~sel_n : '0;
        out_d.sleep = (mode == M_SLEEP);
        out_d.drive = (mode == M_READ) ? ~sel_n : '0;
        for (int l = 0; l < LANES; l++) begin
            out_d.rdata[l*LANE_W +: LANE_W] =
                out_d.drive[l] ? mem_word[l*LANE_W +: LANE_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.drive <= '0;
            out_q.sleep <= 1'b1;
            out_q.rdata <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign drive = out_q.drive;
    assign sleep = out_q.sleep;
    assign rdata = out_q.rdata;

    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (drive == '0 && sleep && rdata == '0));
    p_nolane_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && &sel_n) |=> (drive == '0 && !sleep));
    p_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> drive == '0);
    p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && !oe_n) |=> drive == ~$past(sel_n));
    p_muted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n && oe_n) |=> drive == '0);
endmodule

// File: rtl/dp_byte_ram.sv
module dp_byte_ram
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_hi_n,
    input  logic              l_lo_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [15:0]       l_wdata,
    output logic [15:0]       l_rdata,
    output logic [1:0]        l_drive,
    output logic              l_sleep,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_hi_n,
    input  logic              r_lo_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [15:0]       r_wdata,
    output logic [15:0]       r_rdata,
    output logic [1:0]        r_drive,
    output logic              r_sleep
);
    logic [NPORTS-1:0]                cs_n_v, we_n_v, oe_n_v, sleep_v;
    logic [NPORTS-1:0][LANES-1:0]     sel_n_v, wr_lanes_v, drive_v;
    logic [NPORTS-1:0][ADDR_W-1:0]    addr_v;
    logic [NPORTS-1:0][WORD_W-1:0]    wdata_v, rd_word_v, rdata_v;

    // Index 0 is the left port, index 1 the right port.
    assign cs_n_v  = {r_cs_n, l_cs_n};
    assign we_n_v  = {r_we_n, l_we_n};
    assign oe_n_v  = {r_oe_n, l_oe_n};
    assign sel_n_v = {{r_hi_n, r_lo_n}, {l_hi_n, l_lo_n}};
    assign addr_v  = {r_addr, l_addr};
    assign wdata_v = {r_wdata, l_wdata};

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dp_port_unit #(.ADDR_W(ADDR_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .cs_n     (cs_n_v[p]),
            .we_n     (we_n_v[p]),
            .oe_n     (oe_n_v[p]),
            .sel_n    (sel_n_v[p]),
            .mem_word (rd_word_v[p]),
            .wr_lanes (wr_lanes_v[p]),
            .drive    (drive_v[p]),
            .sleep    (sleep_v[p]),
            .rdata    (rdata_v[p])
        );
    end

    dp_word_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lanes (wr_lanes_v),
        .addr     (addr_v),
        .wdata    (wdata_v),
        .rd_word  (rd_word_v)
    );

    assign l_rdata = rdata_v[0];
    assign l_drive = drive_v[0];
    assign l_sleep = sleep_v[0];
    assign r_rdata = rdata_v[1];
    assign r_drive = drive_v[1];
    assign r_sleep = sleep_v[1];
endmodule

// File: tb/dp_byte_ram_test.sv
module dp_byte_ram_test;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cs_n = 2'b11, we_n = 2'b11, oe_n = 2'b11, hi_n = 2'b11, lo_n = 2'b11;
    logic [1:0][AW-1:0] addr = '0;
    logic [1:0][15:0]   wdata = '0;
    logic [1:0][15:0]   rdata;
    logic [1:0][1:0]    drive;
    logic [1:0]         sleep;
    logic [15:0] ref_mem [DEPTH];
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dp_byte_ram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(cs_n[0]), .l_we_n(we_n[0]), .l_oe_n(oe_n[0]), .l_hi_n(hi_n[0]), .l_lo_n(lo_n[0]),
        .l_addr(addr[0]), .l_wdata(wdata[0]), .l_rdata(rdata[0]), .l_drive(drive[0]), .l_sleep(sleep[0]),
        .r_cs_n(cs_n[1]), .r_we_n(we_n[1]), .r_oe_n(oe_n[1]), .r_hi_n(hi_n[1]), .r_lo_n(lo_n[1]),
        .r_addr(addr[1]), .r_wdata(wdata[1]), .r_rdata(rdata[1]), .r_drive(drive[1]), .r_sleep(sleep[1])
    );

    task automatic check(input string tag, input int p, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %0d actual drive=%b sleep=%b data=%h expected drive=%b sleep=%b data=%h",
                     tag, p, act[18:17], act[16], act[15:0], exp[18:17], exp[16], exp[15:0]);
        end
    endtask

    function automatic logic [18:0] model_out(int p);
        logic [1:0] lanes;
        logic [15:0] d;
        if (cs_n[p]) return {2'b00, 1'b1, 16'h0};
        lanes = (we_n[p] && !oe_n[p]) ? ~{hi_n[p], lo_n[p]} : 2'b00;
        d = ref_mem[addr[p]] & {{8{lanes[1]}}, {8{lanes[0]}}};
        return {lanes, 1'b0, d};
    endfunction

    function automatic string mode_tag(int p);
        if (cs_n[p])                  return "R1";
        if (hi_n[p] && lo_n[p])       return "R2";
        if (!we_n[p])                 return "R3";
        if (!oe_n[p])                 return "R4";
        return "R5";
    endfunction

    task automatic set_port(input int p, input logic c, input logic w, input logic o,
                            input logic h, input logic l, input int a, input logic [15:0] d);
        cs_n[p] = c; we_n[p] = w; oe_n[p] = o; hi_n[p] = h; lo_n[p] = l;
        addr[p] = AW'(a); wdata[p] = d;
    endtask

    // One clock: predict, update reference (right first, left wins), compare.
    task automatic cycle(input string tag0, input string tag1);
        logic [1:0][18:0] exp;
        for (int p = 0; p < 2; p++) exp[p] = model_out(p);
        for (int p = 1; p >= 0; p--) begin
            if (!cs_n[p] && !we_n[p]) begin
                if (!hi_n[p]) ref_mem[addr[p]][15:8] = wdata[p][15:8];
                if (!lo_n[p]) ref_mem[addr[p]][7:0]  = wdata[p][7:0];
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag0, 0, {drive[0], sleep[0], rdata[0]}, exp[0]);
        check(tag1, 1, {drive[1], sleep[1], rdata[1]}, exp[1]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=still running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) check("R9", p, {drive[p], sleep[p], rdata[p]}, {2'b00, 1'b1, 16'h0});
        rst_n = 1'b1;
        // fill memory through the left port, full words
        for (int a = 0; a < DEPTH; a++) begin
            set_port(0, 0, 0, 1, 0, 0, a, 16'(a * 16'h1357 + 16'h2468));
            set_port(1, 1, 1, 1, 1, 1, 0, 16'h0);
            cycle("R3", "R1");
        end
        // every control combination on each port, other port deselected
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 32; c++) begin
                set_port(p, c[4], c[3], c[2], c[1], c[0], (c * 3 + p) % DEPTH, 16'(c * 16'h0F1D ^ 16'hB00C));
                set_port(1 - p, 1, 1, 1, 1, 1, 0, 16'h0);
                cycle(mode_tag(0), mode_tag(1));
                // read back the same word through the same port: proves what was or was not written
                set_port(p, 0, 1, 0, 0, 0, (c * 3 + p) % DEPTH, 16'h0);
                cycle(p == 0 ? "R3" : "R1", p == 1 ? "R3" : "R1");
            end
        end
        // both ports read the same word together
        for (int a = 0; a < DEPTH; a++) begin
            set_port(0, 0, 1, 0, 0, 0, a, 16'h0);
            set_port(1, 0, 1, 0, 0, 0, a, 16'h0);
            cycle("R6", "R6");
        end
        // write-write collision, all nonempty lane pairings
        for (int ml = 1; ml < 4; ml++) begin
            for (int mr = 1; mr < 4; mr++) begin
                set_port(0, 0, 0, 1, !ml[1], !ml[0], 7, 16'(16'hA100 + ml * 16'h0011));
                set_port(1, 0, 0, 1, !mr[1], !mr[0], 7, 16'(16'h5E00 + mr * 16'h0101));
                cycle("R7", "R7");
                set_port(0, 0, 1, 0, 0, 0, 7, 16'h0);
                set_port(1, 0, 1, 0, 0, 0, 7, 16'h0);
                cycle("R7", "R7");
            end
        end
        // read during the other port's write returns old data, then new data
        for (int p = 0; p < 2; p++) begin
            set_port(p, 0, 0, 1, 0, 0, 9 + p, 16'(16'hC3A0 + p));
            set_port(1 - p, 0, 1, 0, 0, 0, 9 + p, 16'h0);
            cycle("R8", "R8");
            set_port(p, 1, 1, 1, 1, 1, 0, 16'h0);
            cycle("R8", "R8");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule